// File: doc/BRIEF.md
# Antenna Diversity RSSI Sampling Controller

This block runs the received-signal-strength sampling for a receiver with two antennas. A down-counting dwell timer marks out fixed-length dwells. At a programmed count within each dwell it starts a conversion of the signal-strength input. It also flips the antenna select each time the timer reloads. The conversion takes a programmed number of cycles. At its end the 7-bit value is latched into a readable sample register and compared with a lower limit. The result drives an above-limit flag and a busy-channel indication.

With the use-strength enable set, a dwell whose result reaches the limit locks the current antenna. Sampling still goes on in every dwell, and the busy-channel flag follows the newest result. An external-trigger mode replaces the timer with rising edges on a pin, which are synchronized inside the block. An external-converter mode takes the value from a digital input bus and raises a power-control output for the length of each conversion. The converted value can be presented on an output bus when that bus is enabled.

Top module: `rssi_div_ctrl`

## Requirements
- R1: After reset the dwell timer repeats every `dwell_len` cycles (`dwell_len` >= 2). The first reload edge is edge `dwell_len`+1 after reset release. Without an active lock, `ant_sel` inverts on every reload edge.
- R2: In timer mode a conversion starts on the edge after the one that loads the timer with `sample_at`, which is edge `dwell_len`+1-`sample_at` of the first dwell. It lasts `conv_time` cycles, and the sample is latched on edge `dwell_len`+1-`sample_at`+`conv_time`. The sample register changes at no other time. The constraint is `conv_time` < `sample_at` < `dwell_len`.
- R3: The latched value is `adc_in0` when `src_sel`=0 and `adc_in1` when `src_sel`=1. When `ext_adc_mode`=1 it is `ext_sar_in`.
- R4: `above_limit` is 1 exactly when the latest latched sample is >= `rssi_limit`.
- R5: With `use_rssi`=1, a reload that ends a dwell with a passing result sets a lock. From then on `ant_sel` holds, while samples keep being latched every dwell.
- R6: Clearing `use_rssi` drops the lock, and toggling resumes at the next reload.
- R7: `cca_busy` equals `use_rssi` AND `above_limit`.
- R8: With `ext_trig_mode`=1 the timer starts no conversion. A rising edge on `ext_trig_pin` passes a two-flop synchronizer, and the conversion starts on the third edge after the pin rises.
- R9: A trigger that arrives while a conversion is in progress is dropped.
- R10: `conv_pwr` is 1 for exactly the `conv_time` cycles of a conversion when `ext_adc_mode`=1, and is 0 otherwise.
- R11: `sar_out` shows the sample when `sar_en`=1 and `ext_adc_mode`=0, and is 0 otherwise.
- R12: After reset, `ant_sel`, `conv_pwr`, `rssi_sample`, `above_limit`, `cca_busy` and `sar_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dwell_len | input | 6 | Dwell length in cycles |
| sample_at | input | 6 | Timer count at which a conversion starts |
| conv_time | input | 4 | Conversion length in cycles |
| rssi_limit | input | 7 | Lower limit for the comparison |
| use_rssi | input | 1 | Lets the result drive the lock and busy-channel flag |
| src_sel | input | 1 | Selects between the two internal inputs |
| ext_trig_mode | input | 1 | Conversions are started by pin edges |
| ext_adc_mode | input | 1 | Value comes from the external converter bus |
| sar_en | input | 1 | Enables the sample output bus |
| ext_trig_pin | input | 1 | Asynchronous external trigger |
| adc_in0 | input | 7 | Converted value, source 0 |
| adc_in1 | input | 7 | Converted value, source 1 |
| ext_sar_in | input | 7 | Value from the external converter |
| ant_sel | output | 1 | Antenna select |
| conv_pwr | output | 1 | External converter power control |
| rssi_sample | output | 7 | Latched sample register |
| above_limit | output | 1 | Latest sample >= limit |
| cca_busy | output | 1 | Channel judged busy |
| sar_out | output | 7 | Sample output bus |

## Verification
The bench builds the block with its default widths: a 6-bit timer, 7-bit values and a 4-bit conversion count. It runs with a dwell of 8, a sample point of 5, a conversion length of 3 and a limit of 40. In that setting the captures land on edges 7, 15, 23 and so on after reset, and the antenna reloads on edges 9, 17 and so on. Every one of the 128 sample codes can be swept in one dwell each, which exercises both sides of the comparison, both sources, the output-bus gating and the antenna parity. Short directed runs reach the locking sequence, the synchronizer delay and an edge dropped during a busy conversion.

// File: rtl/rdc_pkg.sv
package rdc_pkg;
  parameter int unsigned RDC_TMR_W  = 6;
  parameter int unsigned RDC_VAL_W  = 7;
  parameter int unsigned RDC_CT_W   = 4;
  parameter int unsigned RDC_SYNC_N = 2;

  typedef enum logic {
    TRIG_TIMER = 1'b0,
    TRIG_PIN   = 1'b1
  } rdc_trig_e;
endpackage

// File: rtl/rdc_dwell_timer.sv
module rdc_dwell_timer #(
  parameter int unsigned TMR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TMR_W-1:0] dwell_len,
  input  logic [TMR_W-1:0] sample_at,
  output logic             wrap,
  output logic             hit
);
  logic [TMR_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;

  always_comb begin
    run_d = 1'b1;
    if (cnt_q == '0) cnt_d = dwell_len - 1'b1;
    else             cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign wrap = run_q && (cnt_q == '0);
  assign hit  = run_q && (cnt_q == sample_at);

  a_r1_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/rdc_trig_sync.sv
module rdc_trig_sync #(
  parameter int unsigned SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise
);
  logic [SYNC_N-1:0] sync_q, sync_d;
  logic              prev_q;

  generate
    if (SYNC_N == 1) begin : g_one
      always_comb sync_d = pin;
    end else begin : g_many
      always_comb sync_d = {sync_q[SYNC_N-2:0], pin};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[SYNC_N-1];
    end
  end

  assign rise = sync_q[SYNC_N-1] & ~prev_q;

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/rdc_conv_seq.sv
module rdc_conv_seq #(
  parameter int unsigned VAL_W = 7,
  parameter int unsigned CT_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CT_W-1:0]  conv_time,
  input  logic [VAL_W-1:0] value,
  input  logic [VAL_W-1:0] limit,
  output logic             busy,
  output logic             done_pass,
  output logic [VAL_W-1:0] sample,
  output logic             above
);
  logic             busy_q, busy_d;
  logic [CT_W-1:0]  ccnt_q, ccnt_d;
  logic [VAL_W-1:0] sample_q;
  logic             above_q;
  logic             last, start_ok, pass_now;

  assign last     = busy_q && (ccnt_q <= 1);
  assign start_ok = start && !busy_q;
  assign pass_now = (value >= limit);

  always_comb begin
    busy_d = busy_q;
    ccnt_d = ccnt_q;
    if (start_ok) begin
      busy_d = 1'b1;
      ccnt_d = conv_time;
    end else if (last) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      ccnt_d = ccnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ccnt_q <= '0;
    end else begin
      busy_q <= busy_d;
      ccnt_q <= ccnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_q <= '0;
      above_q  <= 1'b0;
    end else if (last) begin
      sample_q <= value;
      above_q  <= pass_now;
    end
  end

  assign busy      = busy_q;
  assign done_pass = last && pass_now;
  assign sample    = sample_q;
  assign above     = above_q;

  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |=> $stable(sample_q));
  a_r9_run_length: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && ccnt_q > 1) |=> (busy_q && ccnt_q == $past(ccnt_q) - 1'b1));
  a_r4_compare: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> (above_q == (sample_q >= $past(limit))));
endmodule

// File: rtl/rssi_div_ctrl.sv
module rssi_div_ctrl
  import rdc_pkg::*;
#(
  parameter int unsigned TMR_W  = RDC_TMR_W,
  parameter int unsigned VAL_W  = RDC_VAL_W,
  parameter int unsigned CT_W   = RDC_CT_W,
  parameter int unsigned SYNC_N = RDC_SYNC_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TMR_W-1:0] dwell_len,
  input  logic [TMR_W-1:0] sample_at,
  input  logic [CT_W-1:0]  conv_time,
  input  logic [VAL_W-1:0] rssi_limit,
  input  logic             use_rssi,
  input  logic             src_sel,
  input  logic             ext_trig_mode,
  input  logic             ext_adc_mode,
  input  logic             sar_en,
  input  logic             ext_trig_pin,
  input  logic [VAL_W-1:0] adc_in0,
  input  logic [VAL_W-1:0] adc_in1,
  input  logic [VAL_W-1:0] ext_sar_in,
  output logic             ant_sel,
  output logic             conv_pwr,
  output logic [VAL_W-1:0] rssi_sample,
  output logic             above_limit,
  output logic             cca_busy,
  output logic [VAL_W-1:0] sar_out
);
  logic             wrap, hit, pin_rise, start;
  logic             busy, done_pass, above;
  logic [VAL_W-1:0] conv_val, sample;
  rdc_trig_e        trig_src;

  logic ant_q, ant_d, lock_q, lock_d, pass_q, pass_d, pass_dwell, lock_eff;

  rdc_dwell_timer #(.TMR_W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .dwell_len(dwell_len), .sample_at(sample_at),
    .wrap(wrap), .hit(hit)
  );

  rdc_trig_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(ext_trig_pin), .rise(pin_rise)
  );

  assign trig_src = ext_trig_mode ? TRIG_PIN : TRIG_TIMER;
  assign start    = (trig_src == TRIG_PIN) ? pin_rise : hit;
  assign conv_val = ext_adc_mode ? ext_sar_in : (src_sel ? adc_in1 : adc_in0);

  rdc_conv_seq #(.VAL_W(VAL_W), .CT_W(CT_W)) u_conv (
    .clk(clk), .rst_n(rst_n), .start(start), .conv_time(conv_time),
    .value(conv_val), .limit(rssi_limit), .busy(busy), .done_pass(done_pass),
    .sample(sample), .above(above)
  );

  // diversity decision
  assign pass_dwell = pass_q || done_pass;
  assign lock_eff   = lock_q && use_rssi;

  always_comb begin
    pass_d = pass_q;
    lock_d = lock_q;
    ant_d  = ant_q;
    if (wrap)           pass_d = 1'b0;
    else if (done_pass) pass_d = 1'b1;
    if (!use_rssi)                lock_d = 1'b0;
    else if (wrap && pass_dwell)  lock_d = 1'b1;
    if (wrap && !lock_eff && !(use_rssi && pass_dwell)) ant_d = ~ant_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ant_q  <= 1'b0;
      lock_q <= 1'b0;
      pass_q <= 1'b0;
    end else begin
      ant_q  <= ant_d;
      lock_q <= lock_d;
      pass_q <= pass_d;
    end
  end

  assign ant_sel     = ant_q;
  assign conv_pwr    = busy && ext_adc_mode;
  assign rssi_sample = sample;
  assign above_limit = above;
  assign cca_busy    = use_rssi && above;
  assign sar_out     = (sar_en && !ext_adc_mode) ? sample : '0;

  a_r5_hold_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && lock_q && use_rssi) |=> $stable(ant_q));
  a_r8_timer_muted: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_trig_mode && !pin_rise && !busy) |=> !busy);
  a_r1_toggle_free: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !use_rssi) |=> (ant_q != $past(ant_q)));
endmodule

// File: tb/rssi_div_ctrl_bench.sv
module rssi_div_ctrl_bench;
  logic       clk, rst_n;
  logic [5:0] dwell_len, sample_at;
  logic [3:0] conv_time;
  logic [6:0] rssi_limit, adc_in0, adc_in1, ext_sar_in;
  logic       use_rssi, src_sel, ext_trig_mode, ext_adc_mode, sar_en, ext_trig_pin;
  logic       ant_sel, conv_pwr, above_limit, cca_busy;
  logic [6:0] rssi_sample, sar_out;
  int         n_chk, n_bad, ecnt;

  rssi_div_ctrl u_rssi_div_ctrl (
    .clk(clk), .rst_n(rst_n), .dwell_len(dwell_len), .sample_at(sample_at),
    .conv_time(conv_time), .rssi_limit(rssi_limit), .use_rssi(use_rssi),
    .src_sel(src_sel), .ext_trig_mode(ext_trig_mode), .ext_adc_mode(ext_adc_mode),
    .sar_en(sar_en), .ext_trig_pin(ext_trig_pin), .adc_in0(adc_in0),
    .adc_in1(adc_in1), .ext_sar_in(ext_sar_in), .ant_sel(ant_sel),
    .conv_pwr(conv_pwr), .rssi_sample(rssi_sample), .above_limit(above_limit),
    .cca_busy(cca_busy), .sar_out(sar_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) ecnt <= 0;
    else        ecnt <= ecnt + 1;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at edge %0d: actual %0d expected %0d", req, ecnt, act, exp);
    end
  endtask

  task automatic at_edge(input int k);
    while (ecnt < k) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    dwell_len = 6'd8; sample_at = 6'd5; conv_time = 4'd3; rssi_limit = 7'd40;
    use_rssi = 0; src_sel = 0; ext_trig_mode = 0; ext_adc_mode = 0; sar_en = 0;
    ext_trig_pin = 0; adc_in0 = 0; adc_in1 = 0; ext_sar_in = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    do_reset();
    // R12 reset state
    sar_en = 1; use_rssi = 1;
    chk("R12 ant", ant_sel, 0);       chk("R12 pwr", conv_pwr, 0);
    chk("R12 sample", rssi_sample, 0); chk("R12 above", above_limit, 0);
    chk("R12 cca", cca_busy, 0);       chk("R12 sar", sar_out, 0);

    // R2 / R10 / R11 timing in external-converter mode
    do_reset();
    ext_adc_mode = 1; ext_sar_in = 50; sar_en = 1;
    at_edge(3); chk("R2 pwr before start", conv_pwr, 0);
    at_edge(4); chk("R10 pwr on", conv_pwr, 1);
    at_edge(6); chk("R10 pwr held", conv_pwr, 1); chk("R2 no early capture", rssi_sample, 0);
    at_edge(7); chk("R10 pwr off", conv_pwr, 0); chk("R3 ext value", rssi_sample, 50);
    chk("R11 sar off in ext mode", sar_out, 0);
    ext_sar_in = 9;
    at_edge(11); chk("R10 pwr idle", conv_pwr, 0);
    at_edge(12); chk("R2 second dwell start", conv_pwr, 1);
    at_edge(15); chk("R2 second capture", rssi_sample, 9);

    // Sweep all codes: R1 R3 R4 R11
    do_reset();
    for (int v = 0; v < 128; v++) begin
      src_sel = v[0]; sar_en = v[1];
      adc_in0 = v[0] ? 7'(127 - v) : 7'(v);
      adc_in1 = v[0] ? 7'(v) : 7'(127 - v);
      at_edge(7 + 8 * v);
      chk("R3 sample", rssi_sample, v);
      chk("R4 above", above_limit, (v >= 40) ? 1 : 0);
      chk("R11 sar", sar_out, v[1] ? v : 0);
      chk("R1 ant parity", ant_sel, v & 1);
      chk("R7 cca off", cca_busy, 0);
    end

    // Lock sequence R5 R6 R7
    do_reset();
    use_rssi = 1; adc_in0 = 10;
    at_edge(8);  chk("R1 before reload", ant_sel, 0);
    at_edge(9);  chk("R1 reload toggle", ant_sel, 1);
    at_edge(15); adc_in0 = 90;
    at_edge(17); chk("R1 second toggle", ant_sel, 0);
    at_edge(23); chk("R7 cca busy", cca_busy, 1); adc_in0 = 10;
    at_edge(25); chk("R5 locked hold", ant_sel, 0);
    at_edge(31); chk("R5 sampling continues", above_limit, 0); chk("R7 cca clear", cca_busy, 0);
    at_edge(33); chk("R5 still held", ant_sel, 0);
    at_edge(41); chk("R5 held later", ant_sel, 0);
    use_rssi = 0; adc_in0 = 90;
    at_edge(47); chk("R7 cca gated", cca_busy, 0); chk("R4 above set", above_limit, 1);
    at_edge(49); chk("R6 toggling resumes", ant_sel, 1);
    at_edge(57); chk("R6 toggles again", ant_sel, 0);

    // External trigger R8 R9
    do_reset();
    ext_trig_mode = 1; ext_adc_mode = 1; ext_sar_in = 77;
    at_edge(5);  chk("R8 timer ignored", conv_pwr, 0);
    at_edge(10); ext_trig_pin = 1;
    at_edge(11); ext_trig_pin = 0;
    at_edge(12); chk("R8 sync delay", conv_pwr, 0); ext_trig_pin = 1;
    at_edge(13); chk("R8 start", conv_pwr, 1);
    at_edge(15); chk("R8 running", conv_pwr, 1);
    at_edge(16); chk("R8 capture", rssi_sample, 77); chk("R8 pwr off", conv_pwr, 0);
    ext_sar_in = 5;
    at_edge(17); chk("R9 edge dropped", conv_pwr, 0);
    at_edge(18); chk("R9 still idle", conv_pwr, 0);
    at_edge(20); ext_trig_pin = 0;
    at_edge(30); chk("R8 no timer capture", rssi_sample, 77); ext_trig_pin = 1;
    at_edge(32); chk("R8 idle before start", conv_pwr, 0);
    at_edge(33); chk("R8 restart", conv_pwr, 1);
    at_edge(36); chk("R8 new sample", rssi_sample, 5); chk("R4 below", above_limit, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule